// File: doc/BRIEF.md
# Residual-Variable Multiplexer Lookup Element

This block evaluates any Boolean function of `N` input variables with a multiplexer that has only 2^(N-1) data inputs, half the size of a plain lookup table. The upper `N-1` variables steer a tree of cascaded 2:1 multiplexers. Each data input of that tree is fed from one of four sources chosen by a two-bit code: logic zero, logic one, the lowest variable, or the inverse of the lowest variable.

A configuration word holds one two-bit code per tree input. Software or a generator derives it from a truth table by looking at each pair of rows that differ only in the lowest variable. The block drives the function value combinationally and also through a clock-enabled output register for pipelined use.

Top module: `lutmux_resid`

## Requirements
- R1: For any function of the N variables, `f_o` equals truth-table bit `x_i` (with `x_i` read as an unsigned index) when entry k is set from rows 2k (low) and 2k+1 (high) as: both 0 gives code 00, both 1 gives 01, low 0 and high 1 gives 10, low 1 and high 0 gives 11.
- R2: A selected entry holding code 2'b00 makes `f_o` 0 for both values of `x_i[0]`.
- R3: A selected entry holding code 2'b01 makes `f_o` 1 for both values of `x_i[0]`.
- R4: A selected entry holding code 2'b10 makes `f_o` equal to `x_i[0]`.
- R5: A selected entry holding code 2'b11 makes `f_o` equal to the inverse of `x_i[0]`.
- R6: The selected entry index is `x_i[N-1:1]` read as a binary number with `x_i[N-1]` as most significant bit; entry k occupies `cfg_i[2k+1:2k]`.
- R7: While `rst_n` is low, `f_q_o` is 0, without waiting for a clock edge.
- R8: With `ce` high at a rising clock edge, `f_q_o` takes the value `f_o` had before that edge.
- R9: With `ce` low at a rising clock edge, `f_q_o` keeps its value.
- R10: Entries other than the selected one have no effect on `f_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| ce | input | 1 | Load enable of the output register |
| x_i | input | N | Function variables; bit 0 is the residual variable |
| cfg_i | input | 2*2^(N-1) | One two-bit source code per tree input |
| f_o | output | 1 | Function value, combinational |
| f_q_o | output | 1 | Function value, registered |

## Verification
The clocked checks assume `x_i`, `cfg_i` and `ce` settle between edges and are stable around each rising edge, since the combinational path is only sampled there. The stimulus changes every input on the falling edge, so each check at the next rising edge sees settled values. The checks also assume `rst_n` is driven low from time zero, which the stimulus does before any clock activity.

// File: rtl/lutmux_pkg.sv
package lutmux_pkg;

  // Source of one multiplexer data input
  typedef enum logic [1:0] {
    SRC_ZERO = 2'b00,
    SRC_ONE  = 2'b01,
    SRC_VAR  = 2'b10,
    SRC_NVAR = 2'b11
  } src_e;

endpackage

// File: rtl/lutmux_src.sv
module lutmux_src
  import lutmux_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  logic [2*ENTRIES-1:0] cfg_i,
  input  logic                 xl_i,
  output logic [ENTRIES-1:0]   data_o
);

  // One source selector per tree input
  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    src_e code;
    assign code = src_e'(cfg_i[2*k +: 2]);

    always_comb begin
      unique case (code)
        SRC_ZERO: data_o[k] = 1'b0;
        SRC_ONE:  data_o[k] = 1'b1;
        SRC_VAR:  data_o[k] = xl_i;
        SRC_NVAR: data_o[k] = ~xl_i;
        default:  data_o[k] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/lutmux_tree.sv
module lutmux_tree #(
  parameter int unsigned SELS = 3
) (
  input  logic [(2**SELS)-1:0] d_i,
  input  logic [SELS-1:0]      sel_i,
  output logic                 y_o
);

  // Level l halves the width using select bit l; the root uses the MSB.
  for (genvar l = 0; l < SELS; l++) begin : g_lvl
    localparam int unsigned W = 2 ** (SELS - l - 1);
    logic [W-1:0] v;
    for (genvar k = 0; k < W; k++) begin : g_mux
      if (l == 0) begin : g_first
        assign v[k] = sel_i[0] ? d_i[2*k+1] : d_i[2*k];
      end else begin : g_next
        assign v[k] = sel_i[l] ? g_lvl[l-1].v[2*k+1] : g_lvl[l-1].v[2*k];
      end
    end
  end

  assign y_o = g_lvl[SELS-1].v[0];

endmodule

// File: rtl/lutmux_resid.sv
module lutmux_resid
  import lutmux_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce,
  input  logic [N-1:0]               x_i,
  input  logic [2*(2**(N-1))-1:0]    cfg_i,
  output logic                       f_o,
  output logic                       f_q_o
);

  localparam int unsigned SELS    = N - 1;
  localparam int unsigned ENTRIES = 2 ** SELS;

  logic [ENTRIES-1:0] data_w;
  logic [SELS-1:0]    sel_w;
  logic               fq_r;
  logic               fq_nxt;

  assign sel_w = x_i[N-1:1];

  lutmux_src #(.ENTRIES(ENTRIES)) u_src (
    .cfg_i  (cfg_i),
    .xl_i   (x_i[0]),
    .data_o (data_w)
  );

  lutmux_tree #(.SELS(SELS)) u_tree (
    .d_i   (data_w),
    .sel_i (sel_w),
    .y_o   (f_o)
  );

  // Output register: next-state and storage kept apart
  always_comb begin
    fq_nxt = ce ? f_o : fq_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fq_r <= 1'b0;
    else        fq_r <= fq_nxt;
  end

  assign f_q_o = fq_r;

  // Assertions
  logic [1:0] cur_code;
  assign cur_code = cfg_i[2*sel_w +: 2];

  assert_tree_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    f_o == data_w[sel_w]);

  assert_code_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_code == SRC_ZERO) |-> (f_o == 1'b0));

  assert_code_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_code == SRC_ONE) |-> (f_o == 1'b1));

  assert_code_var_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_code == SRC_VAR) |-> (f_o == x_i[0]));

  assert_code_nvar_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_code == SRC_NVAR) |-> (f_o == !x_i[0]));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (f_q_o == $past(f_o)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(f_q_o));

  assert_reset_R7: assert property (@(posedge clk)
    !rst_n |-> (f_q_o == 1'b0));

endmodule

// File: tb/sim_lutmux_resid.sv
module sim_lutmux_resid;

  localparam int unsigned NV    = 4;
  localparam int unsigned ENT   = 2 ** (NV - 1);
  localparam int unsigned CW    = 2 * ENT;
  localparam int unsigned ROWS  = 2 ** NV;
  localparam time         CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce;
  logic [NV-1:0] x;
  logic [CW-1:0] cfg;
  logic          f;
  logic          fq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lutmux_resid #(.N(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .x_i(x), .cfg_i(cfg),
    .f_o(f), .f_q_o(fq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %b expected %b (x=%b cfg=%h)", req, act, exp, x, cfg);
    end
  endtask

  task automatic drive(input logic [NV-1:0] xv, input logic [CW-1:0] cv);
    @(negedge clk);
    x = xv;
    cfg = cv;
    #1;
  endtask

  // Truth table to codes: pattern of rows (2k, 2k+1)
  function automatic logic [CW-1:0] tt2cfg(input logic [ROWS-1:0] tt);
    logic [CW-1:0] c = '0;
    for (int k = 0; k < ENT; k++) begin
      case ({tt[2*k+1], tt[2*k]})
        2'b00: c[2*k +: 2] = 2'b00;
        2'b11: c[2*k +: 2] = 2'b01;
        2'b10: c[2*k +: 2] = 2'b10;
        default: c[2*k +: 2] = 2'b11;
      endcase
    end
    return c;
  endfunction

  function automatic logic code_val(input logic [1:0] c, input logic xl);
    case (c)
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return xl;
      default: return ~xl;
    endcase
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; ce = 1'b1; x = '0; cfg = {ENT{2'b01}};
    #1;
    chk("R7", fq, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    chk("R7", fq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_codes;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        drive(NV'(r), {ENT{2'(c)}});
        case (c)
          0: chk("R2", f, 1'b0);
          1: chk("R3", f, 1'b1);
          2: chk("R4", f, x[0]);
          default: chk("R5", f, ~x[0]);
        endcase
      end
    end
  endtask

  task automatic t_reference;
    // F(A,B,C) = m0+m2+m6+m7 with A=x[2],B=x[1],C=x[0]; x[3] ignored
    logic [7:0] fr = 8'b1100_0101;
    logic [CW-1:0] cv = {2{8'b01_00_11_11}};
    for (int r = 0; r < ROWS; r++) begin
      drive(NV'(r), cv);
      chk("R1", f, fr[r % 8]);
    end
  endtask

  task automatic t_random;
    for (int t = 0; t < 12; t++) begin
      logic [ROWS-1:0] tt = ROWS'($urandom());
      if (t == 0) tt = '0;
      if (t == 1) tt = '1;
      for (int r = 0; r < ROWS; r++) begin
        drive(NV'(r), tt2cfg(tt));
        chk("R1", f, tt[r]);
      end
    end
  endtask

  task automatic t_index;
    // Only entry k = ONE, rest ZERO: output high exactly when x[NV-1:1]==k
    for (int k = 0; k < ENT; k++) begin
      logic [CW-1:0] cv = '0;
      cv[2*k +: 2] = 2'b01;
      for (int r = 0; r < ROWS; r++) begin
        drive(NV'(r), cv);
        chk("R6", f, (r / 2) == k);
      end
    end
  endtask

  task automatic t_unselected;
    for (int t = 0; t < 6; t++) begin
      logic [CW-1:0] base = CW'({$urandom(), $urandom()});
      logic [NV-1:0] xv = NV'($urandom());
      int sel = int'(xv[NV-1:1]);
      logic exp = code_val(base[2*sel +: 2], xv[0]);
      for (int j = 0; j < ENT; j++) begin
        if (j != sel) begin
          for (int c = 0; c < 4; c++) begin
            logic [CW-1:0] cv = base;
            cv[2*j +: 2] = 2'(c);
            drive(xv, cv);
            chk("R10", f, exp);
          end
        end
      end
    end
  endtask

  task automatic t_register;
    logic held;
    ce = 1'b1;
    drive(NV'(1), {ENT{2'b10}});       // f = 1
    @(posedge clk); #1;
    chk("R8", fq, 1'b1);
    drive(NV'(0), {ENT{2'b10}});       // f = 0
    @(posedge clk); #1;
    chk("R8", fq, 1'b0);
    drive(NV'(3), {ENT{2'b01}});       // f = 1
    ce = 1'b0;
    held = fq;
    @(posedge clk); #1;
    chk("R9", fq, held);
    @(posedge clk); #1;
    chk("R9", fq, held);
    @(negedge clk);
    ce = 1'b1;
    @(posedge clk); #1;
    chk("R8", fq, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7", fq, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(7));
    t_reset();
    t_codes();
    t_reference();
    t_random();
    t_index();
    t_unselected();
    t_register();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule